// File: doc/BRIEF.md
# Dual-Mode Instruction Dispatch Unit

This block sits between the instruction expansion queue and the decode stage of an in-order core. Each cycle it looks at a window of up to seven queued instructions, starting with the oldest. It decides how many of them leave the queue together, and it assigns each one to a function unit. The queue pops as many entries as the block reports.

A mode input is sampled every cycle and selects one of two policies:

- **Superscalar (mode low).** At most two instructions issue, strictly in program order. A per-register countdown scoreboard holds back any instruction whose source is still being produced.
- **VLIW (mode high).** Up to seven instructions issue as one group. A group runs only while function-unit classes keep rising through integer, multiply, load/store, branch, and only while units of each class remain. No dependence check is made, because software guarantees that instructions in a group are independent.

A stall input freezes all issue. The execution latencies of the units still count down during a stall.

Top module: `dmd_dispatch_top`

## Requirements
- R1: Issue never exceeds 2 instructions per cycle when `mode_vliw`=0, or 7 when it is 1. The issued slots always form a contiguous run starting at slot 0, and `iss_count` equals the number of asserted `iss_valid` bits.
- R2: When `mode_vliw`=0, an instruction issues only if none of its two sources is busy in the scoreboard. An instruction also does not issue if either of its sources equals the enabled destination of an older instruction in the same window.
- R3: Class codes are 0=integer, 1=multiply, 2=load/store, 3=branch. An issued instruction with `dst_en`=1 makes its destination busy. A dependent instruction issued in superscalar mode can go no earlier than 1, 2 or 3 cycles after an integer, multiply or load/store producer, respectively.
- R4: When `mode_vliw`=0 and slot 0 cannot issue, slot 1 does not issue either.
- R5: When `mode_vliw`=1, slot k joins the group only if its class code is not below the class code of slot k-1. A lower code ends the group.
- R6: In both modes, a group ends at the first instruction whose class already has all of its units used by older members of the group (2 integer, 2 multiply, 2 load/store, 1 branch). It also ends at the first slot whose `q_valid` bit is 0.
- R7: When `mode_vliw`=1, source and destination registers, and the scoreboard, have no effect on issue.
- R8: An issued slot receives unit code 0/1 for integer, 2/3 for multiply, 4/5 for load/store and 6 for branch. The lower code of a pair goes to the older instruction of that class. A slot that does not issue reports unit code 0.
- R9: While `stall`=1 no slot issues and no destination is marked busy, yet busy countdowns keep running.
- R10: A change of `mode_vliw` takes effect on the issue outputs in the same cycle, without waiting for a clock edge.
- R11: A synchronous reset clears every scoreboard entry, including entries in the middle of a countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_vliw | input | 1 | 1 selects grouped VLIW issue, 0 selects scoreboard-checked in-order issue |
| stall | input | 1 | Suppresses all issue for the cycle |
| q_valid | input | 7 | Per-slot valid for the queue window, slot 0 oldest |
| q_class | input | 14 | 2-bit class code per slot |
| q_src_a | input | 28 | First source register index per slot (4 bits each) |
| q_src_b | input | 28 | Second source register index per slot |
| q_dst | input | 28 | Destination register index per slot |
| q_dst_en | input | 7 | Per-slot flag that the instruction writes its destination |
| iss_valid | output | 7 | Per-slot issue strobe |
| iss_unit | output | 21 | 3-bit function unit code per slot |
| iss_count | output | 3 | Number of issued slots, used to pop the queue |

## Verification
The hardest conditions to reach are the exact release cycle of a busy register and the behaviour of that countdown when a stall or a reset lands in the middle of it. A look at a single cycle cannot show either one. The stimulus issues one producer of each latency class and then holds a dependent at the head of the window. It counts the cycles until the dependent leaves, and repeats this with stall cycles inserted and with a reset pulse placed during the countdown. The grouping rules are covered by a table of windows that break the class order, overfill one class, or run out of valid entries, and each window is applied under both mode values.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

    localparam int SLOT_N   = 7;
    localparam int SS_WIDTH = 2;
    localparam int REG_N    = 16;
    localparam int REG_W    = $clog2(REG_N);

    localparam int N_ALU = 2;
    localparam int N_MUL = 2;
    localparam int N_LSU = 2;
    localparam int N_BR  = 1;
    localparam int UNIT_N = N_ALU + N_MUL + N_LSU + N_BR;
    localparam int UNIT_W = $clog2(UNIT_N);

    localparam int LAT_ALU = 1;
    localparam int LAT_MUL = 2;
    localparam int LAT_LSU = 3;
    localparam int LAT_BR  = 1;
    localparam int LAT_MAX = (LAT_LSU > LAT_MUL) ? ((LAT_LSU > LAT_ALU) ? LAT_LSU : LAT_ALU)
                                                 : ((LAT_MUL > LAT_ALU) ? LAT_MUL : LAT_ALU);
    localparam int CNT_W   = (LAT_MAX > 2) ? $clog2(LAT_MAX) : 1;
    localparam int CW      = $clog2(SLOT_N + 1);

    typedef enum logic [1:0] {
        FU_ALU = 2'd0,
        FU_MUL = 2'd1,
        FU_LSU = 2'd2,
        FU_BR  = 2'd3
    } fu_cls_e;

    typedef struct packed {
        logic             vld;
        fu_cls_e          cls;
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
        logic [REG_W-1:0] dst;
        logic             dst_en;
    } instr_t;

    function automatic logic [CW-1:0] cls_units(fu_cls_e c);
        case (c)
            FU_ALU:  return CW'(N_ALU);
            FU_MUL:  return CW'(N_MUL);
            FU_LSU:  return CW'(N_LSU);
            default: return CW'(N_BR);
        endcase
    endfunction

    function automatic logic [UNIT_W-1:0] cls_base(fu_cls_e c);
        case (c)
            FU_ALU:  return UNIT_W'(0);
            FU_MUL:  return UNIT_W'(N_ALU);
            FU_LSU:  return UNIT_W'(N_ALU + N_MUL);
            default: return UNIT_W'(N_ALU + N_MUL + N_LSU);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] cls_hold(fu_cls_e c);
        case (c)
            FU_ALU:  return CNT_W'(LAT_ALU - 1);
            FU_MUL:  return CNT_W'(LAT_MUL - 1);
            FU_LSU:  return CNT_W'(LAT_LSU - 1);
            default: return CNT_W'(LAT_BR - 1);
        endcase
    endfunction

endpackage

// File: rtl/dmd_scoreboard.sv
module dmd_scoreboard
    import dmd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [SLOT_N-1:0]      set_en,
    input  logic [SLOT_N-1:0]      dst_en,
    input  logic [REG_W-1:0]       dst [SLOT_N],
    input  fu_cls_e                cls [SLOT_N],
    output logic [REG_N-1:0]       busy
);

    logic [CNT_W-1:0] cnt [REG_N];
    logic [CNT_W-1:0] nxt [REG_N];

    // countdown per register; the youngest writer in the window wins
    always_comb begin
        for (int r = 0; r < REG_N; r++) begin
            nxt[r] = (cnt[r] != '0) ? cnt[r] - CNT_W'(1) : '0;
            for (int s = 0; s < SLOT_N; s++) begin
                if (set_en[s] && dst_en[s] && (dst[s] == REG_W'(r)))
                    nxt[r] = cls_hold(cls[s]);
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < REG_N; r++) begin
            if (rst) cnt[r] <= '0;
            else     cnt[r] <= nxt[r];
        end
    end

    generate
        for (genvar r = 0; r < REG_N; r++) begin : g_busy
            assign busy[r] = (cnt[r] != '0);
        end
    endgenerate

endmodule

// File: rtl/dmd_ss_pick.sv
module dmd_ss_pick
    import dmd_pkg::*;
(
    input  instr_t             win [SLOT_N],
    input  logic [REG_N-1:0]   busy,
    output logic [SLOT_N-1:0]  ok
);

    logic          chain;
    logic          blocked;
    logic [CW-1:0] same_n;

    always_comb begin
        chain   = 1'b1;
        blocked = 1'b0;
        same_n  = '0;
        ok      = '0;
        for (int k = 0; k < SLOT_N; k++) begin
            if (k < SS_WIDTH) begin
                blocked = !win[k].vld || busy[win[k].src_a] || busy[win[k].src_b];
                same_n  = '0;
                for (int j = 0; j < k; j++) begin
                    if (win[j].dst_en &&
                        (win[j].dst == win[k].src_a || win[j].dst == win[k].src_b))
                        blocked = 1'b1;
                    if (win[j].cls == win[k].cls)
                        same_n = same_n + CW'(1);
                end
                if (same_n >= cls_units(win[k].cls))
                    blocked = 1'b1;
                chain = chain && !blocked;
                ok[k] = chain;
            end
        end
    end

endmodule

// File: rtl/dmd_vliw_group.sv
module dmd_vliw_group
    import dmd_pkg::*;
(
    input  logic [SLOT_N-1:0]  vld,
    input  fu_cls_e            cls [SLOT_N],
    output logic [SLOT_N-1:0]  ok
);

    logic          chain;
    logic          blocked;
    logic [CW-1:0] same_n;

    always_comb begin
        chain   = 1'b1;
        blocked = 1'b0;
        same_n  = '0;
        for (int k = 0; k < SLOT_N; k++) begin
            blocked = !vld[k];
            if (k > 0 && (cls[k] < cls[k-1]))
                blocked = 1'b1;
            same_n = '0;
            for (int j = 0; j < k; j++) begin
                if (cls[j] == cls[k])
                    same_n = same_n + CW'(1);
            end
            if (same_n >= cls_units(cls[k]))
                blocked = 1'b1;
            chain = chain && !blocked;
            ok[k] = chain;
        end
    end

endmodule

// File: rtl/dmd_unit_map.sv
module dmd_unit_map
    import dmd_pkg::*;
(
    input  logic [SLOT_N-1:0]  issue,
    input  fu_cls_e            cls [SLOT_N],
    output logic [UNIT_W-1:0]  unit [SLOT_N]
);

    logic [CW-1:0] rank;

    always_comb begin
        rank = '0;
        for (int k = 0; k < SLOT_N; k++) begin
            rank = '0;
            for (int j = 0; j < k; j++) begin
                if (issue[j] && cls[j] == cls[k])
                    rank = rank + CW'(1);
            end
            unit[k] = issue[k] ? cls_base(cls[k]) + UNIT_W'(rank) : '0;
        end
    end

endmodule

// File: rtl/dmd_dispatch_top.sv
module dmd_dispatch_top
    import dmd_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      mode_vliw,
    input  logic                      stall,
    input  logic [SLOT_N-1:0]         q_valid,
    input  logic [2*SLOT_N-1:0]       q_class,
    input  logic [REG_W*SLOT_N-1:0]   q_src_a,
    input  logic [REG_W*SLOT_N-1:0]   q_src_b,
    input  logic [REG_W*SLOT_N-1:0]   q_dst,
    input  logic [SLOT_N-1:0]         q_dst_en,
    output logic [SLOT_N-1:0]         iss_valid,
    output logic [UNIT_W*SLOT_N-1:0]  iss_unit,
    output logic [CW-1:0]             iss_count
);

    instr_t             win   [SLOT_N];
    fu_cls_e            cls   [SLOT_N];
    logic [REG_W-1:0]   dst   [SLOT_N];
    logic [UNIT_W-1:0]  unit  [SLOT_N];
    logic [SLOT_N-1:0]  ss_ok;
    logic [SLOT_N-1:0]  vl_ok;
    logic [REG_N-1:0]   busy;

    generate
        for (genvar k = 0; k < SLOT_N; k++) begin : g_slot
            assign cls[k]        = fu_cls_e'(q_class[2*k +: 2]);
            assign dst[k]        = q_dst[REG_W*k +: REG_W];
            assign win[k].vld    = q_valid[k];
            assign win[k].cls    = cls[k];
            assign win[k].src_a  = q_src_a[REG_W*k +: REG_W];
            assign win[k].src_b  = q_src_b[REG_W*k +: REG_W];
            assign win[k].dst    = dst[k];
            assign win[k].dst_en = q_dst_en[k];
            assign iss_unit[UNIT_W*k +: UNIT_W] = unit[k];
        end
    endgenerate

    dmd_ss_pick u_ss (
        .win  (win),
        .busy (busy),
        .ok   (ss_ok)
    );

    dmd_vliw_group u_vliw (
        .vld (q_valid),
        .cls (cls),
        .ok  (vl_ok)
    );

    assign iss_valid = stall ? '0 : (mode_vliw ? vl_ok : ss_ok);

    dmd_unit_map u_map (
        .issue (iss_valid),
        .cls   (cls),
        .unit  (unit)
    );

    dmd_scoreboard u_sb (
        .clk    (clk),
        .rst    (rst),
        .set_en (iss_valid),
        .dst_en (q_dst_en),
        .dst    (dst),
        .cls    (cls),
        .busy   (busy)
    );

    always_comb begin
        iss_count = '0;
        for (int k = 0; k < SLOT_N; k++)
            iss_count = iss_count + CW'(iss_valid[k]);
    end

    logic [UNIT_N-1:0] unit_occ;
    always_comb begin
        unit_occ = '0;
        for (int k = 0; k < SLOT_N; k++)
            if (iss_valid[k]) unit_occ[unit[k]] = 1'b1;
    end

    p_ss_width_r1: assert property (@(posedge clk) disable iff (rst)
        !mode_vliw |-> ($countones(iss_valid) <= SS_WIDTH));

    p_prefix_r1: assert property (@(posedge clk) disable iff (rst)
        ((iss_valid & (iss_valid + SLOT_N'(1))) == '0));

    p_src_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (!mode_vliw && iss_valid[0]) |-> (!busy[win[0].src_a] && !busy[win[0].src_b]));

    p_unit_distinct_r8: assert property (@(posedge clk) disable iff (rst)
        $countones(unit_occ) == $countones(iss_valid));

    p_stall_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
        stall |=> ((busy & ~$past(busy)) == '0));

endmodule

// File: tb/tb_dmd_dispatch_top.sv
`timescale 1ns/1ps
module tb_dmd_dispatch_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_vliw = 1'b0;
    logic        stall = 1'b0;
    logic [6:0]  q_valid = '0;
    logic [13:0] q_class = '0;
    logic [27:0] q_src_a = '0;
    logic [27:0] q_src_b = '0;
    logic [27:0] q_dst = '0;
    logic [6:0]  q_dst_en = '0;
    logic [6:0]  iss_valid;
    logic [20:0] iss_unit;
    logic [2:0]  iss_count;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dmd_dispatch_top dut (
        .clk(clk), .rst(rst), .mode_vliw(mode_vliw), .stall(stall),
        .q_valid(q_valid), .q_class(q_class), .q_src_a(q_src_a), .q_src_b(q_src_b),
        .q_dst(q_dst), .q_dst_en(q_dst_en),
        .iss_valid(iss_valid), .iss_unit(iss_unit), .iss_count(iss_count)
    );

    typedef struct packed {
        logic        mode;
        logic [6:0]  vld;
        logic [13:0] cls;
        logic [27:0] sa;
        logic [27:0] sb;
        logic [27:0] dst;
        logic [6:0]  den;
        logic [6:0]  exp_v;
        logic [20:0] exp_u;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        // R1 R8: full VLIW group in class order
        '{1'b1, 7'h7F, 14'b11_10_10_01_01_00_00, 28'h0, 28'h0, 28'h0, 7'h00, 7'h7F, 21'o6543210},
        // R5: class falls back to integer in slot 2
        '{1'b1, 7'h7F, 14'b00_00_00_00_00_01_00, 28'h0, 28'h0, 28'h0, 7'h00, 7'h03, 21'o0000020},
        // R6: third integer op
        '{1'b1, 7'h7F, 14'b00_00_00_00_00_00_00, 28'h0, 28'h0, 28'h0, 7'h00, 7'h03, 21'o0000010},
        // R6: second branch
        '{1'b1, 7'h7F, 14'b11_11_11_11_11_11_11, 28'h0, 28'h0, 28'h0, 7'h00, 7'h01, 21'o0000006},
        // R6: window runs empty after three
        '{1'b1, 7'h07, 14'b00_00_00_00_11_10_00, 28'h0, 28'h0, 28'h0, 7'h00, 7'h07, 21'o0000640},
        // R7: dependent pair still groups
        '{1'b1, 7'h03, 14'b00_00_00_00_00_01_00, 28'h0000050, 28'h0, 28'h0000005, 7'h01, 7'h03, 21'o0000020},
        // R1: superscalar caps at two
        '{1'b0, 7'h7F, 14'b00_00_00_00_00_00_00, 28'h0, 28'h0, 28'h0, 7'h00, 7'h03, 21'o0000010},
        // R2: src_a of slot 1 hits dst of slot 0
        '{1'b0, 7'h03, 14'b00_00_00_00_00_00_00, 28'h0000030, 28'h0, 28'h0000003, 7'h01, 7'h01, 21'o0000000},
        // R6: one branch unit in superscalar mode
        '{1'b0, 7'h7F, 14'b11_11_11_11_11_11_11, 28'h0, 28'h0, 28'h0, 7'h00, 7'h01, 21'o0000006},
        // R8: multiply then load/store
        '{1'b0, 7'h03, 14'b00_00_00_00_00_10_01, 28'h0, 28'h0, 28'h0, 7'h00, 7'h03, 21'o0000042},
        // R8: descending classes fine in superscalar
        '{1'b0, 7'h03, 14'b00_00_00_00_00_00_10, 28'h0, 28'h0, 28'h0, 7'h00, 7'h03, 21'o0000004},
        // R5: same window cut in VLIW
        '{1'b1, 7'h03, 14'b00_00_00_00_00_00_10, 28'h0, 28'h0, 28'h0, 7'h00, 7'h01, 21'o0000004},
        // R2: src_b of slot 1 hits dst of slot 0
        '{1'b0, 7'h03, 14'b00_00_00_00_00_00_01, 28'h0, 28'h0000070, 28'h0000007, 7'h01, 7'h01, 21'o0000002}
    };

    task automatic chk(input string req, input logic [6:0] ev, input logic [20:0] eu);
        logic [2:0] ec;
        ec = 3'($countones(ev));
        n_chk++;
        if (iss_valid !== ev || iss_unit !== eu || iss_count !== ec) begin
            n_bad++;
            $display("FAIL %s: valid=%h unit=%o count=%0d expected valid=%h unit=%o count=%0d",
                     req, iss_valid, iss_unit, iss_count, ev, eu, ec);
        end
    endtask

    task automatic clear_win();
        q_valid = '0; q_class = '0; q_src_a = '0; q_src_b = '0; q_dst = '0; q_dst_en = '0;
    endtask

    // slot 0 only
    task automatic put0(input logic [1:0] c, input logic [3:0] sa, input logic [3:0] d, input logic de);
        clear_win();
        q_valid = 7'h01; q_class = {12'b0, c}; q_src_a = {24'h0, sa}; q_dst = {24'h0, d}; q_dst_en = {6'b0, de};
    endtask

    task automatic idle(input int n);
        clear_win();
        stall = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic lat_test(input logic [1:0] c, input logic [3:0] d, input int exp_lat, input string req);
        int n;
        @(negedge clk);
        mode_vliw = 1'b0;
        put0(c, 4'd0, d, 1'b1);
        @(negedge clk);
        put0(2'd0, d, 4'd0, 1'b0);
        #2;
        n = 1;
        while (!iss_valid[0] && n < 6) begin
            @(negedge clk); #2; n++;
        end
        n_chk++;
        if (n != exp_lat) begin
            n_bad++;
            $display("FAIL %s: dependent issued after %0d cycles, expected %0d", req, n, exp_lat);
        end
        idle(4);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        chk("R11 reset state", 7'h00, 21'o0);

        foreach (VEC[i]) begin
            @(negedge clk);
            mode_vliw = VEC[i].mode;
            q_valid = VEC[i].vld; q_class = VEC[i].cls;
            q_src_a = VEC[i].sa; q_src_b = VEC[i].sb; q_dst = VEC[i].dst; q_dst_en = VEC[i].den;
            #2;
            chk($sformatf("vector %0d (R1 R2 R5 R6 R7 R8)", i), VEC[i].exp_v, VEC[i].exp_u);
            idle(4);
        end

        // R3 release timing per class
        lat_test(2'd0, 4'd6, 1, "R3 integer latency");
        lat_test(2'd1, 4'd7, 2, "R3 multiply latency");
        lat_test(2'd2, 4'd8, 3, "R3 load latency");

        // R4 blocked head holds slot 1
        @(negedge clk);
        mode_vliw = 1'b0;
        put0(2'd2, 4'd0, 4'd10, 1'b1);
        @(negedge clk);
        clear_win();
        q_valid = 7'h03; q_src_a = 28'h000001A;
        #2;
        chk("R4 blocked head", 7'h00, 21'o0);
        idle(4);

        // R9 stalled producer is not recorded
        @(negedge clk);
        stall = 1'b1;
        put0(2'd2, 4'd0, 4'd11, 1'b1);
        #2;
        chk("R9 stall blocks issue", 7'h00, 21'o0);
        @(negedge clk);
        stall = 1'b0;
        put0(2'd0, 4'd11, 4'd0, 1'b0);
        #2;
        chk("R9 stalled dst not busy", 7'h01, 21'o0);
        idle(4);

        // R9 countdown runs during stall
        @(negedge clk);
        put0(2'd2, 4'd0, 4'd12, 1'b1);
        @(negedge clk);
        stall = 1'b1;
        put0(2'd0, 4'd12, 4'd0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        stall = 1'b0;
        #2;
        chk("R9 countdown continues in stall", 7'h01, 21'o0);
        idle(4);

        // R10 same-cycle mode change
        @(negedge clk);
        mode_vliw = 1'b0;
        clear_win();
        q_valid = 7'h03; q_class = 14'b00_00_00_00_00_00_10;
        #2;
        chk("R10 superscalar view", 7'h03, 21'o0000004);
        mode_vliw = 1'b1;
        #1;
        chk("R10 VLIW view", 7'h01, 21'o0000004);
        idle(4);

        // R7 busy register ignored in VLIW mode
        @(negedge clk);
        mode_vliw = 1'b0;
        put0(2'd2, 4'd0, 4'd14, 1'b1);
        @(negedge clk);
        mode_vliw = 1'b1;
        put0(2'd0, 4'd14, 4'd0, 1'b0);
        #2;
        chk("R7 scoreboard ignored", 7'h01, 21'o0);
        idle(4);

        // R11 reset mid-countdown
        @(negedge clk);
        mode_vliw = 1'b0;
        put0(2'd2, 4'd0, 4'd9, 1'b1);
        @(negedge clk);
        clear_win();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        put0(2'd0, 4'd9, 4'd0, 1'b0);
        #2;
        chk("R11 reset clears busy", 7'h01, 21'o0);
        idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule